// File: doc/BRIEF.md
# Shared-Address Configuration Register Pair

This block places two 8-bit configuration registers of a serial peripheral behind a single bus address. One register holds the upper bits of the baud-rate divisor; the other holds the frame-control settings. The bus interface is a plain synchronous strobe port with a chip select, a write strobe, a read strobe, write data and registered read data.

On a write, bit 7 of the data word picks the target register. A clear bit 7 loads the baud-high register, which keeps only its low four bits. A set bit 7 loads the frame-control register, which keeps bits 6..0. On a read, the block checks whether the previous cycle was also a read of the address. A read with no read just before it returns the baud-high value. A read in the cycle right after another read returns the frame-control value. Software therefore has to issue the two reads back to back, with interrupts masked. The register contents are also driven out continuously to the serial engine.

Top module: `shared_addr_regpair`

## Requirements
- R1: After a synchronous reset, `baud_hi` is 0x0, `frame_cfg` is 0x06, `rdata` is 0x00, and no read is recorded as previous.
- R2: A cycle with `cs`=1, `wr_en`=1 and `wdata[7]`=0 loads `wdata[3:0]` into `baud_hi` at that clock edge and leaves `frame_cfg` unchanged.
- R3: A cycle with `cs`=1, `wr_en`=1 and `wdata[7]`=1 loads `wdata[6:0]` into `frame_cfg` at that clock edge and leaves `baud_hi` unchanged.
- R4: A read (`cs`=1, `rd_en`=1, `wr_en`=0) whose previous cycle was not a read returns {4'b0000, `baud_hi`} on `rdata` after that clock edge.
- R5: A read whose previous cycle was also a read returns {1'b1, `frame_cfg`} on `rdata` after that clock edge.
- R6: Three consecutive read cycles return baud-high, then frame-control, then frame-control.
- R7: Any cycle without a read clears the read history, so a read after an idle cycle or a write returns baud-high again.
- R8: With `cs`=0, the write and read strobes are ignored: neither register changes, `rdata` holds, and the read history clears.
- R9: A cycle with `cs`, `wr_en` and `rd_en` all high acts as a write only. `rdata` holds and the read history clears.
- R10: `rdata` holds its last value in every cycle that is not a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Address match for the shared location |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data; bit 7 selects the target register |
| rdata | output | 8 | Registered read data |
| baud_hi | output | 4 | Stored upper divisor bits |
| frame_cfg | output | 7 | Stored frame-control bits 6..0 |

## Verification
Every result in this block lands at the first rising edge after the stimulus cycle. Register outputs update at the edge that samples the write. `rdata` updates at the edge that samples the read. The read history has a depth of exactly one cycle. The bench drives strobes on the falling edge and samples one nanosecond after the following rising edge, so each read in a back-to-back burst is checked in its own cycle. Gap, chip-select-low and read-with-write cycles are followed at once by a read, which shows through `rdata` whether the history was cleared.

// File: rtl/regpair_pkg.sv
package regpair_pkg;
  localparam int DW      = 8;
  localparam int HI_BITS = 4;
  localparam int FR_BITS = DW - 1;
  localparam logic [HI_BITS-1:0] HI_RST = '0;
  localparam logic [FR_BITS-1:0] FR_RST = 7'h06;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_BAUD  = 2'd1,
    SRC_FRAME = 2'd2
  } rd_src_e;
endpackage

// File: rtl/regpair_write_dec.sv
module regpair_write_dec #(
  parameter int DW      = 8,
  parameter int HI_BITS = 4,
  parameter logic [HI_BITS-1:0] HI_RST = '0,
  parameter logic [DW-2:0]      FR_RST = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_hit,
  input  logic [DW-1:0]      wdata,
  output logic [HI_BITS-1:0] hi_q,
  output logic [DW-2:0]      fr_q
);
  localparam int SEL = DW - 1;

  logic ld_hi, ld_fr;
  assign ld_hi = wr_hit & ~wdata[SEL];
  assign ld_fr = wr_hit &  wdata[SEL];

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= HI_RST;
      fr_q <= FR_RST;
    end else begin
      if (ld_hi) hi_q <= wdata[HI_BITS-1:0];
      if (ld_fr) fr_q <= wdata[SEL-1:0];
    end
  end
endmodule

// File: rtl/regpair_rd_track.sv
module regpair_rd_track (
  input  logic clk,
  input  logic rst,
  input  logic rd_hit,
  output regpair_pkg::rd_src_e src,
  output logic prev_rd
);
  import regpair_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) prev_rd <= 1'b0;
    else     prev_rd <= rd_hit;
  end

  always_comb begin
    if (!rd_hit)     src = SRC_NONE;
    else if (prev_rd) src = SRC_FRAME;
    else              src = SRC_BAUD;
  end
endmodule

// File: rtl/regpair_rd_mux.sv
module regpair_rd_mux #(
  parameter int DW      = 8,
  parameter int HI_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  regpair_pkg::rd_src_e src,
  input  logic [HI_BITS-1:0]   hi_q,
  input  logic [DW-2:0]        fr_q,
  output logic [DW-1:0]        rdata
);
  import regpair_pkg::*;

  logic [DW-1:0] hi_ext, fr_ext;

  generate
    if (HI_BITS < DW) begin : g_pad
      assign hi_ext = {{(DW-HI_BITS){1'b0}}, hi_q};
    end else begin : g_full
      assign hi_ext = hi_q[DW-1:0];
    end
  endgenerate

  assign fr_ext = {1'b1, fr_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      unique case (src)
        SRC_BAUD:  rdata <= hi_ext;
        SRC_FRAME: rdata <= fr_ext;
        default:   rdata <= rdata;
      endcase
    end
  end
endmodule

// File: rtl/shared_addr_regpair.sv
module shared_addr_regpair
  import regpair_pkg::*;
#(
  parameter int DW      = regpair_pkg::DW,
  parameter int HI_BITS = regpair_pkg::HI_BITS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rdata,
  output logic [HI_BITS-1:0] baud_hi,
  output logic [DW-2:0]      frame_cfg
);
  logic    wr_hit, rd_hit, prev_rd;
  rd_src_e src;

  // a write in the same cycle wins over a read
  assign wr_hit = cs & wr_en;
  assign rd_hit = cs & rd_en & ~wr_en;

  regpair_write_dec #(
    .DW(DW), .HI_BITS(HI_BITS),
    .HI_RST(HI_RST[HI_BITS-1:0]), .FR_RST(FR_RST[DW-2:0])
  ) u_wr (
    .clk(clk), .rst(rst), .wr_hit(wr_hit), .wdata(wdata),
    .hi_q(baud_hi), .fr_q(frame_cfg)
  );

  regpair_rd_track u_trk (
    .clk(clk), .rst(rst), .rd_hit(rd_hit), .src(src), .prev_rd(prev_rd)
  );

  regpair_rd_mux #(.DW(DW), .HI_BITS(HI_BITS)) u_mux (
    .clk(clk), .rst(rst), .src(src),
    .hi_q(baud_hi), .fr_q(frame_cfg), .rdata(rdata)
  );
endmodule

// File: rtl/regpair_chk.sv
module regpair_chk #(
  parameter int DW      = 8,
  parameter int HI_BITS = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               cs,
  input logic               wr_en,
  input logic               rd_en,
  input logic               wsel,
  input logic [DW-1:0]      rdata,
  input logic [HI_BITS-1:0] baud_hi,
  input logic [DW-2:0]      frame_cfg
);
  logic bus_rd, seen_rd;
  assign bus_rd = cs & rd_en & ~wr_en;

  always_ff @(posedge clk) begin
    if (rst) seen_rd <= 1'b0;
    else     seen_rd <= bus_rd;
  end

  // R2
  hi_write_keeps_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (cs && wr_en && !wsel) |=> $stable(frame_cfg));
  // R3
  frame_write_keeps_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (cs && wr_en && wsel) |=> $stable(baud_hi));
  // R4
  lone_read_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !seen_rd) |=> (rdata == {{(DW-HI_BITS){1'b0}}, $past(baud_hi)}));
  // R5
  paired_read_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && seen_rd) |=> (rdata == {1'b1, $past(frame_cfg)}));
  // R8
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !cs |=> ($stable(baud_hi) && $stable(frame_cfg)));
  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(rdata));
endmodule

bind shared_addr_regpair regpair_chk #(.DW(DW), .HI_BITS(HI_BITS)) u_chk (
  .clk(clk), .rst(rst), .cs(cs), .wr_en(wr_en), .rd_en(rd_en),
  .wsel(wdata[DW-1]), .rdata(rdata), .baud_hi(baud_hi), .frame_cfg(frame_cfg)
);

// File: tb/sim_shared_addr_regpair.sv
`timescale 1ns/1ps
module sim_shared_addr_regpair;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [3:0] baud_hi;
  logic [6:0] frame_cfg;

  int n_chk = 0, n_bad = 0;
  logic [3:0] m_hi = 4'h0;
  logic [6:0] m_fr = 7'h06;
  logic [7:0] got;

  always #4 clk = ~clk;

  shared_addr_regpair u0 (
    .clk(clk), .rst(rst), .cs(cs), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .baud_hi(baud_hi), .frame_cfg(frame_cfg)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one bus cycle; returns rdata sampled after the edge
  task automatic cyc(input logic c, input logic w, input logic r,
                     input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    cs = c; wr_en = w; rd_en = r; wdata = d;
    @(posedge clk); #1;
    q = rdata;
  endtask

  task automatic idle();
    logic [7:0] q;
    cyc(1'b0, 1'b0, 1'b0, 8'h00, q);
  endtask

  task automatic t_reset();
    check("R1 baud_hi", {4'h0, baud_hi}, 8'h00);
    check("R1 frame_cfg", {1'b0, frame_cfg}, 8'h06);
    check("R1 rdata", rdata, 8'h00);
    cyc(1, 0, 1, 8'h00, got); check("R1 first read", got, 8'h00);
    idle();
  endtask

  task automatic t_write_hi(input logic [7:0] d);
    logic [7:0] q;
    cyc(1, 1, 0, d, q);
    m_hi = d[3:0];
    check("R2 baud_hi", {4'h0, baud_hi}, {4'h0, m_hi});
    check("R2 frame kept", {1'b0, frame_cfg}, {1'b0, m_fr});
    idle();
  endtask

  task automatic t_write_fr(input logic [7:0] d);
    logic [7:0] q;
    cyc(1, 1, 0, d, q);
    m_fr = d[6:0];
    check("R3 frame_cfg", {1'b0, frame_cfg}, {1'b0, m_fr});
    check("R3 baud kept", {4'h0, baud_hi}, {4'h0, m_hi});
    idle();
  endtask

  task automatic t_pair();
    cyc(1, 0, 1, 8'h00, got); check("R4 lone read", got, {4'h0, m_hi});
    cyc(1, 0, 1, 8'h00, got); check("R5 paired read", got, {1'b1, m_fr});
    idle();
    check("R10 hold", rdata, {1'b1, m_fr});
  endtask

  task automatic t_triple();
    cyc(1, 0, 1, 8'h00, got); check("R6 read1", got, {4'h0, m_hi});
    cyc(1, 0, 1, 8'h00, got); check("R6 read2", got, {1'b1, m_fr});
    cyc(1, 0, 1, 8'h00, got); check("R6 read3", got, {1'b1, m_fr});
    idle();
  endtask

  task automatic t_gap();
    cyc(1, 0, 1, 8'h00, got);
    idle();
    cyc(1, 0, 1, 8'h00, got); check("R7 after idle", got, {4'h0, m_hi});
    cyc(1, 1, 0, 8'h85, got); m_fr = 7'h05;
    check("R10 hold on write", got, {4'h0, m_hi});
    cyc(1, 0, 1, 8'h00, got); check("R7 after write", got, {4'h0, m_hi});
    idle();
  endtask

  task automatic t_cs_low();
    cyc(1, 0, 1, 8'h00, got);
    cyc(0, 1, 1, 8'h0F, got);
    check("R8 rdata held", got, {4'h0, m_hi});
    check("R8 baud_hi", {4'h0, baud_hi}, {4'h0, m_hi});
    cyc(0, 1, 0, 8'hFF, got);
    check("R8 frame_cfg", {1'b0, frame_cfg}, {1'b0, m_fr});
    cyc(1, 0, 1, 8'h00, got); check("R8 history cleared", got, {4'h0, m_hi});
    idle();
  endtask

  task automatic t_rdwr();
    cyc(1, 0, 1, 8'h00, got);
    cyc(1, 1, 1, 8'h8A, got); m_fr = 7'h0A;
    check("R9 rdata held", got, {4'h0, m_hi});
    check("R9 frame written", {1'b0, frame_cfg}, 8'h0A);
    cyc(1, 0, 1, 8'h00, got); check("R9 history cleared", got, {4'h0, m_hi});
    cyc(1, 0, 1, 8'h00, got); check("R9 frame readback", got, 8'h8A);
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    t_reset();
    t_pair();
    t_write_hi(8'h7B);
    t_write_fr(8'hC3);
    t_pair();
    t_write_hi(8'h05);
    t_write_fr(8'hFF);
    t_triple();
    t_gap();
    t_cs_low();
    t_rdwr();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule